// File: doc/BRIEF.md
# Split-Tenure Bus Slave Terminator

This block is the slave end of a processor bus whose address and data phases are separate tenures. A master presents an address tenure (address, transfer kind, direction) and holds it until the block acknowledges it. The block decodes the transfer and, if it moves data, places it in an in-order pending queue. A data engine then takes the oldest pending transfer and runs its data tenure against a downstream target port with a simple request/ready handshake. It acknowledges each beat back to the bus. Because the two tenures are decoupled, a later address tenure can be acknowledged while an earlier data tenure is still running. Address-only transfers are acknowledged and retired without any data tenure.

The data path width is 32 or 64 bits. A strap input chooses it, and the block captures the strap only while reset is asserted. The width sets the number of beats per transfer and the address step between beats. The top address bit steers every data transfer: it selects either the memory target or the peripheral target.

The block also watches accesses made by an external bus master. When such an access falls in the memory region and the snoop-disable control bit is clear, the block raises a one-cycle snoop request carrying that address to the processor.

Top module: `split_bus_term`

## Requirements
- R1: While `rst` is high, the bus width is loaded from `width_strap` (1 = 64-bit, 0 = 32-bit) and shown on `width64`. Changes on `width_strap` after reset have no effect on `width64`, on beat counts or on beat addresses.
- R2: `aack` is high only in a cycle where `abus_valid` is high. It is combinational: in that same cycle it is high for an address-only kind, and for a data kind whenever the pending queue holds fewer than QDEPTH (default 2) transfers. The kind encodings are 0 = address-only, 1 = single doubleword, 2 = 32-byte line and 3 = reserved, which is treated as address-only.
- R3: An acknowledged address-only or reserved-kind transfer produces no target request and no data beat.
- R4: While the pending queue holds QDEPTH transfers, a data-kind address tenure is not acknowledged. Such a tenure stays unacknowledged even in a cycle in which the head transfer completes.
- R5: In 64-bit mode a single transfer takes 1 beat. In 32-bit mode it takes 2 beats, at the doubleword-aligned address (address with bits 2:0 cleared) and then that address plus 4.
- R6: In 64-bit mode a line transfer takes 4 beats, and in 32-bit mode it takes 8. The first beat is at the line-aligned address (bits 4:0 cleared), and each following beat adds 8 bytes (64-bit mode) or 4 bytes (32-bit mode).
- R7: Data tenures complete in the order their address tenures were acknowledged. `tgt_req` is high whenever a transfer is pending. `dbeat_ack` equals `tgt_req` and `tgt_ready` in the same cycle. `dbeat_last` marks the final beat of each transfer.
- R8: A new address tenure can be acknowledged in a cycle in which an earlier data tenure is in progress.
- R9: During a data tenure, `tgt_sel` equals bit 31 of the transfer address (0 = memory, 1 = peripheral), and `tgt_write` equals the direction captured with the address.
- R10: One cycle after `ext_valid` is high with `ext_addr[31]` = 0 and `snoop_off` = 0, `snoop_req` is high and `snoop_addr` equals that `ext_addr`. In every other case `snoop_req` is low.
- R11: In the first cycle after reset, the queue is empty: `tgt_req`, `dbeat_ack` and `snoop_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| width_strap | input | 1 | Bus width strap, sampled during reset (1 = 64-bit) |
| abus_valid | input | 1 | Address tenure presented, held until acknowledged |
| abus_addr | input | 32 | Transfer address |
| abus_kind | input | 2 | Transfer kind (0 addr-only, 1 single, 2 line, 3 reserved) |
| abus_write | input | 1 | Transfer direction, 1 = write |
| aack | output | 1 | Address tenure acknowledge |
| tgt_ready | input | 1 | Target accepts the current beat |
| tgt_req | output | 1 | Beat request to the target |
| tgt_sel | output | 1 | Target select, 0 = memory, 1 = peripheral |
| tgt_addr | output | 32 | Beat address |
| tgt_write | output | 1 | Beat direction |
| dbeat_ack | output | 1 | Data beat acknowledge to the bus |
| dbeat_last | output | 1 | Final beat of the current data tenure |
| snoop_off | input | 1 | Snoop-disable control bit |
| ext_valid | input | 1 | External master access observed |
| ext_addr | input | 32 | External master access address |
| snoop_req | output | 1 | Snoop request to the processor |
| snoop_addr | output | 32 | Address to snoop |
| width64 | output | 1 | Latched bus width, 1 = 64-bit |

## Verification
The bench stalls the target so that the queue fills. A design that checks fullness badly either overflows and loses a pending transfer, or locks up. The bench also checks the cycle in which a pop and a blocked push coincide. It runs both bus widths, each with single and line transfers, and toggles the strap after reset. A wrong beat count or address step shows up as a misplaced `dbeat_last` or a wrong `tgt_addr`. A strap that is sampled late shows up as a change in beat counts. Random traffic mixes address-only and reserved kinds, which must never create a data tenure, with overlapping address and data tenures. Random external accesses are run with snoop enabled and disabled, which exposes snoops raised for peripheral addresses or raised while snooping is off.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int REGION_BIT = ADDR_W - 1;
    localparam int MAX_BEATS  = LINE_BYTES / 4;
    localparam int BEAT_W     = $clog2(MAX_BEATS);
    localparam int CNT_W      = BEAT_W + 1;

    typedef enum logic [1:0] {
        XK_ADDR_ONLY = 2'd0,
        XK_SINGLE    = 2'd1,
        XK_LINE      = 2'd2,
        XK_RSVD      = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              line;
    } pend_t;

    function automatic logic needs_data(input logic [1:0] k);
        return (k == XK_SINGLE) || (k == XK_LINE);
    endfunction

    function automatic logic [CNT_W-1:0] beat_count(input logic line, input logic wide);
        if (line)
            return wide ? CNT_W'(LINE_BYTES / 8) : CNT_W'(LINE_BYTES / 4);
        return wide ? CNT_W'(1) : CNT_W'(2);
    endfunction

    function automatic logic [ADDR_W-1:0] start_addr(input pend_t e);
        if (e.line)
            return e.addr & ~ADDR_W'(LINE_BYTES - 1);
        return e.addr & ~ADDR_W'(7);
    endfunction

    function automatic int beat_shift(input logic wide);
        return wide ? 3 : 2;
    endfunction
endpackage

// File: rtl/sbt_addr_stage.sv
module sbt_addr_stage
    import sbt_pkg::*;
(
    input  logic              abus_valid,
    input  logic [ADDR_W-1:0] abus_addr,
    input  logic [1:0]        abus_kind,
    input  logic              abus_write,
    input  logic              q_full,
    output logic              aack,
    output logic              push,
    output pend_t             push_ent
);
    logic data_kind;

    always_comb begin
        data_kind      = needs_data(abus_kind);
        aack           = abus_valid && (!data_kind || !q_full);
        push           = aack && data_kind;
        push_ent.addr  = abus_addr;
        push_ent.write = abus_write;
        push_ent.line  = (abus_kind == XK_LINE);
    end
endmodule

// File: rtl/sbt_pend_queue.sv
module sbt_pend_queue #(
    parameter int  DEPTH = 2,
    parameter type T     = logic
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  T     push_ent,
    input  logic pop,
    output logic full,
    output logic empty,
    output T     head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    T                store [DEPTH];
    logic [PW-1:0]   wptr, rptr;
    logic [CW-1:0]   cnt;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) begin
                store[wptr] <= push_ent;
                wptr        <= nxt(wptr);
            end
            if (pop)
                rptr <= nxt(rptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign head  = store[rptr];
endmodule

// File: rtl/sbt_data_engine.sv
module sbt_data_engine
    import sbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              head_valid,
    input  pend_t             head,
    input  logic              tgt_ready,
    output logic              tgt_req,
    output logic              tgt_sel,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              tgt_write,
    output logic              beat_ack,
    output logic              beat_last
);
    logic [BEAT_W-1:0] beat_q;
    logic [CNT_W-1:0]  nbeats;
    logic [ADDR_W-1:0] offset;

    always_comb begin
        nbeats    = beat_count(head.line, wide);
        offset    = ADDR_W'(beat_q) << beat_shift(wide);
        tgt_req   = head_valid;
        tgt_sel   = head.addr[REGION_BIT];
        tgt_write = head.write;
        tgt_addr  = start_addr(head) + offset;
        beat_ack  = tgt_req && tgt_ready;
        beat_last = beat_ack && ({1'b0, beat_q} == nbeats - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            beat_q <= '0;
        else if (beat_last)
            beat_q <= '0;
        else if (beat_ack)
            beat_q <= beat_q + 1'b1;
    end
endmodule

// File: rtl/sbt_snoop_unit.sv
module sbt_snoop_unit
    import sbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              snoop_off,
    input  logic              ext_valid,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              snoop_req,
    output logic [ADDR_W-1:0] snoop_addr
);
    logic hit;
    assign hit = ext_valid && !ext_addr[REGION_BIT] && !snoop_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            snoop_req  <= 1'b0;
            snoop_addr <= '0;
        end else begin
            snoop_req <= hit;
            if (hit)
                snoop_addr <= ext_addr;
        end
    end
endmodule

// File: rtl/split_bus_term.sv
module split_bus_term
    import sbt_pkg::*;
#(
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              width_strap,
    input  logic              abus_valid,
    input  logic [ADDR_W-1:0] abus_addr,
    input  logic [1:0]        abus_kind,
    input  logic              abus_write,
    output logic              aack,
    input  logic              tgt_ready,
    output logic              tgt_req,
    output logic              tgt_sel,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              tgt_write,
    output logic              dbeat_ack,
    output logic              dbeat_last,
    input  logic              snoop_off,
    input  logic              ext_valid,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              snoop_req,
    output logic [ADDR_W-1:0] snoop_addr,
    output logic              width64
);
    logic  wide_q;
    logic  q_full, q_empty, push;
    pend_t push_ent, head;

    always_ff @(posedge clk) begin
        if (rst)
            wide_q <= width_strap;
    end
    assign width64 = wide_q;

    sbt_addr_stage u_addr (
        .abus_valid (abus_valid),
        .abus_addr  (abus_addr),
        .abus_kind  (abus_kind),
        .abus_write (abus_write),
        .q_full     (q_full),
        .aack       (aack),
        .push       (push),
        .push_ent   (push_ent)
    );

    sbt_pend_queue #(.DEPTH(QDEPTH), .T(pend_t)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (dbeat_last),
        .full     (q_full),
        .empty    (q_empty),
        .head     (head)
    );

    sbt_data_engine u_data (
        .clk        (clk),
        .rst        (rst),
        .wide       (wide_q),
        .head_valid (!q_empty),
        .head       (head),
        .tgt_ready  (tgt_ready),
        .tgt_req    (tgt_req),
        .tgt_sel    (tgt_sel),
        .tgt_addr   (tgt_addr),
        .tgt_write  (tgt_write),
        .beat_ack   (dbeat_ack),
        .beat_last  (dbeat_last)
    );

    sbt_snoop_unit u_snoop (
        .clk        (clk),
        .rst        (rst),
        .snoop_off  (snoop_off),
        .ext_valid  (ext_valid),
        .ext_addr   (ext_addr),
        .snoop_req  (snoop_req),
        .snoop_addr (snoop_addr)
    );
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker #(
    parameter int QDEPTH = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        abus_valid,
    input logic [1:0]  abus_kind,
    input logic        aack,
    input logic        tgt_req,
    input logic        tgt_ready,
    input logic        dbeat_ack,
    input logic        dbeat_last,
    input logic        snoop_off,
    input logic        ext_valid,
    input logic [31:0] ext_addr,
    input logic        snoop_req,
    input logic        width64
);
    int  outstanding;
    logic data_push;
    assign data_push = aack && (abus_kind == 2'd1 || abus_kind == 2'd2);

    always_ff @(posedge clk) begin
        if (rst)
            outstanding <= 0;
        else
            outstanding <= outstanding + (data_push ? 1 : 0) - (dbeat_last ? 1 : 0);
    end

    assert_ack_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        aack |-> abus_valid);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        data_push |-> (outstanding < QDEPTH));

    assert_queue_bound_R4: assert property (@(posedge clk) disable iff (rst)
        outstanding <= QDEPTH);

    assert_beat_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
        dbeat_ack |-> (tgt_req && tgt_ready));

    assert_last_is_beat_R7: assert property (@(posedge clk) disable iff (rst)
        dbeat_last |-> dbeat_ack);

    assert_req_only_pending_R3: assert property (@(posedge clk) disable iff (rst)
        tgt_req |-> (outstanding > 0));

    assert_snoop_cause_R10: assert property (@(posedge clk) disable iff (rst)
        (snoop_req && !$past(rst)) |-> ($past(ext_valid) && !$past(snoop_off) && !$past(ext_addr[31])));

    assert_width_held_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(width64));

    assert_empty_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tgt_req && !snoop_req));
endmodule

bind split_bus_term sbt_checker #(.QDEPTH(QDEPTH)) u_sbt_checker (
    .clk        (clk),
    .rst        (rst),
    .abus_valid (abus_valid),
    .abus_kind  (abus_kind),
    .aack       (aack),
    .tgt_req    (tgt_req),
    .tgt_ready  (tgt_ready),
    .dbeat_ack  (dbeat_ack),
    .dbeat_last (dbeat_last),
    .snoop_off  (snoop_off),
    .ext_valid  (ext_valid),
    .ext_addr   (ext_addr),
    .snoop_req  (snoop_req),
    .width64    (width64)
);

// File: tb/split_bus_term_bench.sv
`timescale 1ns/1ps
module split_bus_term_bench;
    localparam int QD = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        width_strap = 1'b1;
    logic        abus_valid = 1'b0;
    logic [31:0] abus_addr = '0;
    logic [1:0]  abus_kind = '0;
    logic        abus_write = 1'b0;
    logic        aack;
    logic        tgt_ready = 1'b0;
    logic        tgt_req, tgt_sel, tgt_write, dbeat_ack, dbeat_last;
    logic [31:0] tgt_addr;
    logic        snoop_off = 1'b0;
    logic        ext_valid = 1'b0;
    logic [31:0] ext_addr = '0;
    logic        snoop_req;
    logic [31:0] snoop_addr;
    logic        width64;

    always #2 clk = ~clk;

    split_bus_term #(.QDEPTH(QD)) u_split_bus_term (
        .clk(clk), .rst(rst), .width_strap(width_strap),
        .abus_valid(abus_valid), .abus_addr(abus_addr), .abus_kind(abus_kind),
        .abus_write(abus_write), .aack(aack), .tgt_ready(tgt_ready),
        .tgt_req(tgt_req), .tgt_sel(tgt_sel), .tgt_addr(tgt_addr),
        .tgt_write(tgt_write), .dbeat_ack(dbeat_ack), .dbeat_last(dbeat_last),
        .snoop_off(snoop_off), .ext_valid(ext_valid), .ext_addr(ext_addr),
        .snoop_req(snoop_req), .snoop_addr(snoop_addr), .width64(width64)
    );

    typedef struct {
        logic [31:0] a;
        bit          w;
        bit          line;
    } ment_t;

    ment_t       mq[$];
    int          beat;
    bit          mwide;
    bit          snp_exp;
    logic [31:0] snp_addr_exp;
    bit          have_req;
    int          rdy_mode;   // 0 random, 1 stalled, 2 always ready
    int          total = 0;
    int          bad = 0;
    int          n_overlap = 0;
    int          n_blocked = 0;
    int          n_blocked_pop = 0;
    int          n_addr_only = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst = 1'b1;
        width_strap = strap;
        abus_valid = 1'b0;
        ext_valid = 1'b0;
        tgt_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mq.delete();
        beat = 0;
        mwide = strap;
        snp_exp = 1'b0;
        have_req = 1'b0;
        #1;
        chk(tgt_req == 1'b0, "R11 tgt_req after reset", 32'(tgt_req), 0);
        chk(dbeat_ack == 1'b0, "R11 dbeat_ack after reset", 32'(dbeat_ack), 0);
        chk(snoop_req == 1'b0, "R11 snoop_req after reset", 32'(snoop_req), 0);
        chk(width64 == strap, "R1 width latched", 32'(width64), 32'(strap));
        width_strap = ~strap;   // R1: strap changes after reset must be ignored
    endtask

    function automatic int nbeats(input bit line, input bit wide);
        if (line) return wide ? 4 : 8;
        return wide ? 1 : 2;
    endfunction

    task automatic run(input int cycles, input bit soff);
        for (int c = 0; c < cycles; c++) begin
            bit          e_aack, e_req, e_ta, e_last, dkind;
            logic [31:0] e_addr, base;
            ment_t       h;
            @(negedge clk);
            if (!have_req && ($urandom % 4 != 0)) begin
                have_req   = 1'b1;
                abus_addr  = $urandom;
                abus_kind  = 2'($urandom % 4);
                abus_write = 1'($urandom % 2);
            end
            abus_valid = have_req;
            case (rdy_mode)
                1:       tgt_ready = 1'b0;
                2:       tgt_ready = 1'b1;
                default: tgt_ready = 1'($urandom % 3 != 0);
            endcase
            snoop_off = soff;
            ext_valid = 1'($urandom % 2);
            ext_addr  = $urandom;
            #1;
            dkind  = have_req && (abus_kind == 2'd1 || abus_kind == 2'd2);
            e_aack = have_req && (!dkind || mq.size() < QD);
            e_req  = mq.size() > 0;
            e_ta   = e_req && tgt_ready;
            e_last = 1'b0;
            chk(aack == e_aack, "R2/R4 aack", 32'(aack), 32'(e_aack));
            chk(tgt_req == e_req, "R3/R7 tgt_req", 32'(tgt_req), 32'(e_req));
            chk(dbeat_ack == e_ta, "R7 dbeat_ack", 32'(dbeat_ack), 32'(e_ta));
            if (e_req) begin
                h = mq[0];
                base = h.line ? {h.a[31:5], 5'b0} : {h.a[31:3], 3'b0};
                e_addr = base + 32'(beat * (mwide ? 8 : 4));
                e_last = e_ta && (beat == nbeats(h.line, mwide) - 1);
                if (h.line)
                    chk(tgt_addr == e_addr, "R6 line beat address", tgt_addr, e_addr);
                else
                    chk(tgt_addr == e_addr, "R5 single beat address", tgt_addr, e_addr);
                chk(tgt_sel == h.a[31], "R9 tgt_sel", 32'(tgt_sel), 32'(h.a[31]));
                chk(tgt_write == h.w, "R9 tgt_write", 32'(tgt_write), 32'(h.w));
            end
            chk(dbeat_last == e_last, "R7 dbeat_last", 32'(dbeat_last), 32'(e_last));
            chk(snoop_req == snp_exp, "R10 snoop_req", 32'(snoop_req), 32'(snp_exp));
            if (snp_exp)
                chk(snoop_addr == snp_addr_exp, "R10 snoop_addr", snoop_addr, snp_addr_exp);
            chk(width64 == mwide, "R1 width held", 32'(width64), 32'(mwide));
            // model advance
            if (e_aack && dkind && e_req) n_overlap++;
            if (have_req && dkind && !e_aack) begin
                n_blocked++;
                if (e_last) n_blocked_pop++;
            end
            if (e_aack && !dkind) n_addr_only++;
            if (e_ta) begin
                if (e_last) begin
                    void'(mq.pop_front());
                    beat = 0;
                end else begin
                    beat++;
                end
            end
            if (e_aack && dkind) begin
                ment_t n;
                n.a = abus_addr;
                n.w = abus_write;
                n.line = (abus_kind == 2'd2);
                mq.push_back(n);
            end
            if (e_aack) have_req = 1'b0;
            snp_exp = ext_valid && !ext_addr[31] && !soff;
            snp_addr_exp = ext_addr;
        end
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rdy_mode = 0;
        do_reset(1'b1);
        run(3000, 1'b0);
        rdy_mode = 1;
        run(200, 1'b0);
        rdy_mode = 0;
        run(600, 1'b1);
        do_reset(1'b0);
        run(3000, 1'b0);
        rdy_mode = 1;
        run(200, 1'b1);
        rdy_mode = 2;
        run(600, 1'b0);
        rdy_mode = 0;
        run(1000, 1'b0);
        chk(n_overlap > 0, "R8 overlapped address ack seen", 32'(n_overlap), 1);
        chk(n_blocked > 0, "R4 full-queue block seen", 32'(n_blocked), 1);
        chk(n_blocked_pop > 0, "R4 blocked during pop seen", 32'(n_blocked_pop), 1);
        chk(n_addr_only > 0, "R3 address-only acks seen", 32'(n_addr_only), 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule